// File: doc/BRIEF.md
# Registered Address Buffer with Parity

This block sits on a memory module between the controller and the memory devices. Each clock it registers a 28-bit command/address word and drives every registered bit out on two identical output buses, so that two banks of loads can be fed from one capture. It also checks even parity over a subset of the word. The subset is chosen by a static configuration pin. The controller sends the parity bit one cycle after the word it covers. The block raises an active-low error flag for that word on the second rising edge after the word was registered.

A gate enable and two active-low chip selects form a power-saving gate. When the gate is on and neither chip select is asserted, the bits outside the parity subset keep their old output values. The subset bits and the parity path keep running. An active-low reset clears the data registers, drives every data output low, holds the error flag deasserted and flushes the parity pipeline.

The block has no flow control. It accepts one word and one parity bit on every clock and cannot stall, so its data path carries no valid/ready handshake.

Top module: `regbuf_parity`

## Requirements
- R1: A word on `din` is captured on a rising edge of `clk` and appears on the outputs just after that same edge.
- R2: `qa` and `qb` carry identical values in every cycle.
- R3: With `cfg_sel` = 0, the parity subset is `din` bits 0–4, 6, 8–11 and 16–27.
- R4: With `cfg_sel` = 1, the parity subset is `din` bits 0–11, 16–19, 21 and 23–27.
- R5: Parity is even: `err_n` is 0 when the ones in the subset of the word, plus its parity bit, add up to an odd count, and 1 otherwise.
- R6: The parity bit for the word captured at edge k is presented on `par_in` at edge k+1. The subset is chosen by `cfg_sel` at edge k+1. The flag for that word appears after edge k+2.
- R7: While `rst_n` is 0, `qa` and `qb` are all zeros and `err_n` is 1.
- R8: After reset is released, `err_n` stays 1 until the flag of the first word captured after reset becomes due (the second edge after that capture). Parity bits presented before that point have no effect.
- R9: When `gate_en` = 1 and both `cs_a_n` and `cs_b_n` are 1, the output bits outside the current parity subset keep their previous values.
- R10: While the gate of R9 is on, the subset bits still capture `din` and the parity check keeps running.
- R11: When `gate_en` is 0, or either chip select is 0, every output bit captures `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sel | input | 1 | Selects the parity subset |
| gate_en | input | 1 | Enables chip-select output gating |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| din | input | 28 | Command/address word |
| par_in | input | 1 | Even parity bit for the previous cycle's word |
| qa | output | 28 | Registered word, copy A |
| qb | output | 28 | Registered word, copy B |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The outputs `qa` and `qb` are due one rising edge after their word is driven. `err_n` is due two edges after its word: the parity bit comes one cycle late, and the checker adds one more register stage. The driver applies inputs on the falling edge. For each edge it pushes into a queue the expected output word and the expected flag. The flag is computed from the word registered two edges before and the parity bit sent one edge before. A monitor samples a quarter period after each rising edge and pops one entry per edge, so every result is compared in exactly the cycle it is due, including the cycles around reset release.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  localparam int unsigned WORD_W = 28;

  // Parity subset for the two configuration settings (bit indices into the word)
  function automatic logic [WORD_W-1:0] cover_mask(input logic alt);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) begin
      if (!alt)
        m[i] = (i <= 4) || (i == 6) || (i >= 8 && i <= 11) || (i >= 16);
      else
        m[i] = (i <= 11) || (i >= 16 && i <= 19) || (i == 21) || (i >= 23);
    end
    return m;
  endfunction

endpackage

// File: rtl/regbuf_gate.sv
module regbuf_gate (
  input  logic gate_en,
  input  logic cs_a_n,
  input  logic cs_b_n,
  output logic hold_en
);

  // Hold is allowed only when gating is enabled and no chip select is active
  always_comb hold_en = gate_en & cs_a_n & cs_b_n;

endmodule

// File: rtl/regbuf_capture.sv
module regbuf_capture #(
  parameter int unsigned DW = regbuf_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_en,
  input  logic [DW-1:0] keep_mask,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic load;
    always_comb load = keep_mask[i] | ~hold_en;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[i] <= 1'b0;
      else if (load) q[i] <= din[i];
    end
  end

  // R7
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (q == '0));

  // R9
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en |=> ((q & ~$past(keep_mask)) == ($past(q) & ~$past(keep_mask))));

  // R10
  subset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((q & $past(keep_mask)) == ($past(din) & $past(keep_mask))));

  // R11
  open_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> (q == $past(din)));

endmodule

// File: rtl/regbuf_parchk.sv
module regbuf_parchk #(
  parameter int unsigned DW = regbuf_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] word_q,
  input  logic [DW-1:0] sel_mask,
  input  logic          par_in,
  output logic          err_n
);

  logic word_vld;   // word_q holds a word captured after reset
  logic pair_vld;   // sum_q/par_q belong to such a word
  logic sum_q;      // XOR of the subset of the registered word
  logic par_q;      // parity bit that arrived one cycle after the word

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_vld <= 1'b0;
      pair_vld <= 1'b0;
      sum_q    <= 1'b0;
      par_q    <= 1'b0;
      err_n    <= 1'b1;
    end else begin
      word_vld <= 1'b1;
      pair_vld <= word_vld;
      sum_q    <= ^(word_q & sel_mask);
      par_q    <= par_in;
      err_n    <= pair_vld ? ~(sum_q ^ par_q) : 1'b1;
    end
  end

  // R7
  err_reset_chk: assert property (@(posedge clk) !rst_n |=> err_n);

  // R8
  err_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_vld |=> err_n);

  // R6
  err_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |=> (err_n == ~($past(sum_q) ^ $past(par_q))));

endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity #(
  parameter int unsigned DW = regbuf_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel,
  input  logic          gate_en,
  input  logic          cs_a_n,
  input  logic          cs_b_n,
  input  logic [DW-1:0] din,
  input  logic          par_in,
  output logic [DW-1:0] qa,
  output logic [DW-1:0] qb,
  output logic          err_n
);

  logic [DW-1:0] mask;
  logic [DW-1:0] word_q;
  logic          hold_en;

  always_comb mask = regbuf_pkg::cover_mask(cfg_sel);

  regbuf_gate u_gate (
    .gate_en (gate_en),
    .cs_a_n  (cs_a_n),
    .cs_b_n  (cs_b_n),
    .hold_en (hold_en)
  );

  regbuf_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_en   (hold_en),
    .keep_mask (mask),
    .din       (din),
    .q         (word_q)
  );

  regbuf_parchk #(.DW(DW)) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_q   (word_q),
    .sel_mask (mask),
    .par_in   (par_in),
    .err_n    (err_n)
  );

  // Both fan-out copies come from the same register
  always_comb begin
    qa = word_q;
    qb = word_q;
  end

endmodule

// File: tb/regbuf_parity_tb.sv
module regbuf_parity_tb;

  localparam int DW = 28;

  typedef struct {
    logic [DW-1:0] q;
    logic          err;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_sel = 1'b0;
  logic          gate_en = 1'b0;
  logic          cs_a_n = 1'b0;
  logic          cs_b_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic          par_in = 1'b0;
  logic [DW-1:0] qa, qb;
  logic          err_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  // bench-side model state
  logic [DW-1:0] m_q = '0;
  logic          m_bad_last = 1'b0;
  int            m_nvalid = 0;
  logic [31:0]   seed = 32'h1234_5679;

  always #10 clk = ~clk;

  regbuf_parity u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .gate_en(gate_en),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .din(din), .par_in(par_in),
    .qa(qa), .qb(qb), .err_n(err_n)
  );

  // R3, R4: subset written from the requirement text
  function automatic logic [DW-1:0] subset(input logic alt);
    logic [DW-1:0] m = '0;
    if (!alt) begin
      m[4:0] = '1; m[6] = 1'b1; m[11:8] = '1; m[27:16] = '1;
    end else begin
      m[11:0] = '1; m[19:16] = '1; m[21] = 1'b1; m[27:23] = '1;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] next_word();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[DW-1:0];
  endfunction

  task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: one clock of stimulus; bad flips the parity bit of the previous word
  task automatic step(input bit rst, input logic [DW-1:0] w, input logic cfg,
                      input logic gen, input logic csa, input logic csb,
                      input bit bad, input string tag);
    exp_t e;
    logic [DW-1:0] m;
    @(negedge clk);
    m       = subset(cfg);
    rst_n   = ~rst;
    din     = w;
    cfg_sel = cfg;
    gate_en = gen;
    cs_a_n  = csa;
    cs_b_n  = csb;
    par_in  = (^(m_q & m)) ^ bad;
    if (rst) begin
      m_q      = '0;
      e.err    = 1'b1;
      m_nvalid = 0;
      bad      = 1'b0;
    end else begin
      e.err = (m_nvalid >= 2) ? ~m_bad_last : 1'b1;
      if (gen && csa && csb) m_q = (w & m) | (m_q & ~m);
      else                   m_q = w;
      m_nvalid++;
    end
    m_bad_last = bad;
    e.q   = m_q;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "qa", qa, e.q);
        check("R2", "qb", qb, e.q);
        check(e.tag, "err_n", {{(DW-1){1'b0}}, err_n}, {{(DW-1){1'b0}}, e.err});
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    for (int i = 0; i < 3; i++) step(1, next_word(), 0, 0, 0, 0, 0, "R7");
    // R8: parity bits before the first due flag are ignored
    step(0, 28'hFFF_FFFF, 0, 0, 0, 0, 1, "R8");
    step(0, 28'h0000_001, 0, 0, 0, 0, 0, "R8");
    // R1, R3, R5, R6: cfg 0 stream with good and bad parity
    for (int i = 0; i < 10; i++) step(0, next_word(), 0, 0, 0, 0, (i % 3) == 1, "R3");
    // single non-subset bits under cfg 0 (bit 5, 7, 12) must not change parity
    step(0, 28'h000_0020, 0, 0, 0, 0, 0, "R3");
    step(0, 28'h000_1080, 0, 0, 0, 0, 0, "R3");
    step(0, 28'h000_0000, 0, 0, 0, 0, 1, "R5");
    step(0, 28'h000_0000, 0, 0, 0, 0, 0, "R6");
    // R4: cfg 1, including bits 5, 7, 20, 22 that only it covers or excludes
    for (int i = 0; i < 10; i++) step(0, next_word(), 1, 0, 0, 0, (i % 4) == 2, "R4");
    step(0, 28'h010_00A0, 1, 0, 0, 0, 0, "R4");
    step(0, 28'h040_0000, 1, 0, 0, 0, 1, "R4");
    step(0, 28'h010_0000, 1, 0, 0, 0, 0, "R4");
    // R9, R10: gate on under cfg 1, then cfg 0
    for (int i = 0; i < 6; i++) step(0, next_word(), 1, 1, 1, 1, i == 3, "R9");
    step(0, 28'h000_0000, 1, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 6; i++) step(0, next_word(), 0, 1, 1, 1, i == 2, "R10");
    // R11: gate enabled but one chip select active, or gating disabled
    step(0, next_word(), 0, 1, 0, 1, 0, "R11");
    step(0, next_word(), 0, 1, 1, 0, 1, "R11");
    step(0, next_word(), 0, 0, 1, 1, 0, "R11");
    step(0, next_word(), 0, 0, 1, 1, 0, "R11");
    // mid-stream reset then R8 again
    step(1, next_word(), 0, 0, 0, 0, 0, "R7");
    step(1, next_word(), 0, 0, 0, 0, 1, "R7");
    step(0, next_word(), 0, 0, 0, 0, 1, "R8");
    step(0, next_word(), 0, 0, 0, 0, 1, "R8");
    step(0, next_word(), 0, 0, 0, 0, 0, "R6");
    step(0, next_word(), 0, 0, 0, 0, 0, "R6");
    step(0, next_word(), 0, 0, 0, 0, 0, "R1");
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule